// File: doc/BRIEF.md
# GPIO Companion Register Block

This block is a small register-mapped companion peripheral with a 16-bit register file and a 16-line GPIO port. A host reaches it over a plain synchronous bus: an address, a write strobe, write data and a combinational read-data return. Write data may be wider than the registers. Only the low 16 bits are kept.

The register file has these parts:
- six plain storage registers (mode, two auxiliary controls, and three interrupt words);
- a read-only status word;
- a power word with a forcing side effect;
- a direction register;
- a level register that can be reached at two aliased addresses.

Each GPIO line drives its output level only while its direction bit selects output. The block keeps the last evaluated output pattern. After a direction or level write, it re-evaluates that pattern and pulses a per-line change flag for every line whose driven level moved.

External input lines can write bits of the level register directly. Such an update is not masked by direction and does not trigger an output evaluation. It only shows up at the outputs after the next direction or level write.

Top module: `gpx_companion`

## Requirements
- R1: After reset the status word (offset 0x08) reads 0x0002. Every other mapped offset reads 0, and `gpio_out` and `out_changed` are 0.
- R2: A write to offset 0x00, 0x04, 0x10, 0x14, 0x18 or 0x1C stores the low 16 bits of `bus_wdata`, and a read of that offset returns them.
- R3: A write to the power word (offset 0x0C) stores the low 16 bits. If bit 7 of the written value is 1, bits 15 and 6 are also set (OR with 0x8040).
- R4: A write to offset 0x24 or 0x28 stores the written value ANDed with the current direction register. Both offsets read the level register. Offset 0x20 reads and writes the direction register.
- R5: In the cycle after a write to offset 0x20, 0x24 or 0x28, `gpio_out` equals level AND direction. For that one cycle, `out_changed` has a 1 on exactly the bits where this value differs from the previous `gpio_out`. For a direction write, the level used is the value held before that edge.
- R6: An external update sets level bit i to `ext_val[i]` wherever `ext_stb[i]` is 1, whatever the direction. It leaves `gpio_out` unchanged and `out_changed` at 0.
- R7: When a level write (0x24 or 0x28) and external strobes occur in the same cycle, the bus value is stored on every bit and the strobes are dropped.
- R8: Reads of any other offset (including misaligned ones) return 0. Writes to unmapped offsets and to the status word change no register and no output.
- R9: `out_changed` is 0 in every cycle that does not directly follow a write to 0x20, 0x24 or 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data; only the low 16 bits are used |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| ext_stb | input | 16 | Per-line strobe for an external level update |
| ext_val | input | 16 | Per-line value applied where the strobe is set |
| gpio_out | output | 16 | Registered driven levels (level AND direction) |
| out_changed | output | 16 | One-cycle per-line pulse on a driven-level change |

## Verification
The bench builds the block with its default parameters: 16 lines equal to the 16-bit register width, an 8-bit address and a 32-bit write bus. With these values the truncation of the upper write half can be exercised, and so can every line of the port and the full status and power constants. The 8-bit address also lets random stimulus reach misaligned and out-of-range offsets next to the eleven mapped ones. The random traffic mixes external strobes with level writes in the same cycle. This makes the bus-priority and no-evaluation cases appear many times, in addition to the directed checks.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   // register slots; the byte offset of slot i is 4*i
   localparam int SL_MODE = 0;
   localparam int SL_AUXD = 1;
   localparam int SL_STAT = 2;
   localparam int SL_PWR  = 3;
   localparam int SL_AUXC = 4;
   localparam int SL_IREQ = 5;
   localparam int SL_IMSK = 6;
   localparam int SL_ISTS = 7;
   localparam int SL_DIR  = 8;
   localparam int SL_LVLW = 9;
   localparam int SL_LVLR = 10;
   localparam int NSLOT   = 11;
   localparam int NCTL    = 8;   // slots held by the control file
endpackage

// File: rtl/gpx_addr_dec.sv
module gpx_addr_dec #(
   parameter int ADDR_W = 8,
   parameter int NSLOT  = 11
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NSLOT-1:0]  sel
);
   localparam int TOP_OFF = 4 * (NSLOT - 1);

   if (TOP_OFF >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gpx_addr_dec: ADDR_W too small for the register map");
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      assign sel[i] = (addr == ADDR_W'(4 * i));
   end
endmodule

// File: rtl/gpx_ctl_regs.sv
module gpx_ctl_regs
   import gpx_pkg::*;
#(
   parameter int             REG_W     = 16,
   parameter logic [15:0]    STAT_INIT = 16'h0002,
   parameter int             PWR_TRIG  = 7,
   parameter logic [15:0]    PWR_FORCE = 16'h8040
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCTL-1:0]            wr_en,
   input  logic [REG_W-1:0]           wdata,
   output logic [NCTL-1:0][REG_W-1:0] val
);
   if (PWR_TRIG >= REG_W) begin : g_bad_trig
      $error("gpx_ctl_regs: PWR_TRIG outside the register");
   end

   localparam logic [REG_W-1:0] FORCE_M = REG_W'(PWR_FORCE);
   localparam logic [REG_W-1:0] STAT_V  = REG_W'(STAT_INIT);

   for (genvar i = 0; i < NCTL; i++) begin : g_reg
      if (i == SL_STAT) begin : g_stat
         // read-only word, no write path
         assign val[i] = STAT_V;
      end else if (i == SL_PWR) begin : g_pwr
         logic [REG_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en[i])
               q <= wdata | (wdata[PWR_TRIG] ? FORCE_M : '0);
         end
         assign val[i] = q;
      end else begin : g_plain
         logic [REG_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en[i])
               q <= wdata;
         end
         assign val[i] = q;
      end
   end
endmodule

// File: rtl/gpx_gpio_core.sv
module gpx_gpio_core #(
   parameter int LINES = 16,
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_we,
   input  logic             lvl_we,
   input  logic [REG_W-1:0] wdata,
   input  logic [LINES-1:0] ext_stb,
   input  logic [LINES-1:0] ext_val,
   output logic [LINES-1:0] level_q,
   output logic [LINES-1:0] dir_q,
   output logic [LINES-1:0] out_q,
   output logic [LINES-1:0] chg_q
);
   if (LINES > REG_W) begin : g_bad_lines
      $error("gpx_gpio_core: LINES exceeds REG_W");
   end

   logic [LINES-1:0] wd;
   logic [LINES-1:0] lvl_nxt;
   logic [LINES-1:0] dir_nxt;
   logic [LINES-1:0] eff;
   logic             eval;

   assign wd = wdata[LINES-1:0];

   // per-line level update: a bus write wins over an external strobe
   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_comb begin
         if (lvl_we)
            lvl_nxt[i] = wd[i] & dir_q[i];
         else if (ext_stb[i])
            lvl_nxt[i] = ext_val[i];
         else
            lvl_nxt[i] = level_q[i];
      end
   end

   assign dir_nxt = dir_we ? wd : dir_q;
   assign eval    = dir_we | lvl_we;
   // a direction write evaluates against the level held before this edge
   assign eff     = (lvl_we ? lvl_nxt : level_q) & dir_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         dir_q   <= '0;
         out_q   <= '0;
         chg_q   <= '0;
      end else begin
         level_q <= lvl_nxt;
         dir_q   <= dir_nxt;
         if (eval) begin
            out_q <= eff;
            chg_q <= eff ^ out_q;
         end else begin
            chg_q <= '0;
         end
      end
   end
endmodule

// File: rtl/gpx_companion.sv
module gpx_companion
   import gpx_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          BUS_W     = 32,
   parameter int          REG_W     = 16,
   parameter int          LINES     = 16,
   parameter logic [15:0] STAT_INIT = 16'h0002,
   parameter int          PWR_TRIG  = 7,
   parameter logic [15:0] PWR_FORCE = 16'h8040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [LINES-1:0]  ext_stb,
   input  logic [LINES-1:0]  ext_val,
   output logic [LINES-1:0]  gpio_out,
   output logic [LINES-1:0]  out_changed
);
   if (BUS_W < REG_W) begin : g_bad_bus
      $error("gpx_companion: BUS_W narrower than REG_W");
   end

   logic [NSLOT-1:0]            sel;
   logic [NSLOT-1:0]            wr;
   logic [REG_W-1:0]            wd;
   logic [NCTL-1:0][REG_W-1:0]  ctl_val;
   logic [LINES-1:0]            level_q;
   logic [LINES-1:0]            dir_q;
   logic [REG_W-1:0]            level_rd;
   logic [REG_W-1:0]            dir_rd;

   assign wd = bus_wdata[REG_W-1:0];
   assign wr = sel & {NSLOT{bus_we}};

   gpx_addr_dec #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   gpx_ctl_regs #(
      .REG_W(REG_W), .STAT_INIT(STAT_INIT),
      .PWR_TRIG(PWR_TRIG), .PWR_FORCE(PWR_FORCE)
   ) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr[NCTL-1:0]),
      .wdata (wd),
      .val   (ctl_val)
   );

   gpx_gpio_core #(.LINES(LINES), .REG_W(REG_W)) u_gpio (
      .clk     (clk),
      .rst_n   (rst_n),
      .dir_we  (wr[SL_DIR]),
      .lvl_we  (wr[SL_LVLW] | wr[SL_LVLR]),
      .wdata   (wd),
      .ext_stb (ext_stb),
      .ext_val (ext_val),
      .level_q (level_q),
      .dir_q   (dir_q),
      .out_q   (gpio_out),
      .chg_q   (out_changed)
   );

   if (LINES < REG_W) begin : g_pad
      assign level_rd = {{(REG_W-LINES){1'b0}}, level_q};
      assign dir_rd   = {{(REG_W-LINES){1'b0}}, dir_q};
   end else begin : g_full
      assign level_rd = level_q;
      assign dir_rd   = dir_q;
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NCTL; i++)
         if (sel[i]) bus_rdata = ctl_val[i];
      if (sel[SL_DIR])                 bus_rdata = dir_rd;
      if (sel[SL_LVLW] | sel[SL_LVLR]) bus_rdata = level_rd;
   end
endmodule

// File: rtl/gpx_companion_chk.sv
module gpx_companion_chk #(
   parameter int          ADDR_W    = 8,
   parameter int          REG_W     = 16,
   parameter int          LINES     = 16,
   parameter logic [15:0] STAT_INIT = 16'h0002
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [REG_W-1:0]  bus_rdata,
   input logic [LINES-1:0]  gpio_out,
   input logic [LINES-1:0]  out_changed
);
   logic eval_wr;
   logic mapped;
   assign eval_wr = bus_we && (bus_addr == ADDR_W'(32) || bus_addr == ADDR_W'(36)
                               || bus_addr == ADDR_W'(40));
   assign mapped  = (bus_addr[1:0] == 2'b00) && (bus_addr <= ADDR_W'(40));

   // R9: no change pulse without an evaluating write in the previous cycle
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(eval_wr) |-> (out_changed == '0));

   // R5: each pulse marks exactly the bits in which the driven output moved
   a_r5_pulse_diff: assert property (@(posedge clk) disable iff (!rst_n)
      out_changed == (gpio_out ^ $past(gpio_out)));

   // R6: outputs hold when no direction or level write occurred
   a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(eval_wr) |-> $stable(gpio_out));

   // R8: unmapped offsets read zero
   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (bus_rdata == '0));

   // R1: the status word always reads its constant
   a_r1_status_const: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(8)) |-> (bus_rdata == REG_W'(STAT_INIT)));
endmodule

bind gpx_companion gpx_companion_chk #(
   .ADDR_W(ADDR_W), .REG_W(REG_W), .LINES(LINES), .STAT_INIT(STAT_INIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_we      (bus_we),
   .bus_rdata   (bus_rdata),
   .gpio_out    (gpio_out),
   .out_changed (out_changed)
);

// File: tb/sim_gpx_companion.sv
module sim_gpx_companion;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] ext_stb = '0;
   logic [15:0] ext_val = '0;
   logic [15:0] gpio_out;
   logic [15:0] out_changed;

   int checks = 0;
   int errors = 0;

   // bench model
   logic [15:0] m_reg [0:7];
   logic [15:0] m_dir, m_lvl, m_out;

   always #2 clk = ~clk;

   gpx_companion u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_stb(ext_stb),
      .ext_val(ext_val), .gpio_out(gpio_out), .out_changed(out_changed)
   );

   task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(logic [7:0] a);
      if (a[1:0] != 2'b00 || a > 8'h28) return 16'h0;
      if (a == 8'h20) return m_dir;
      if (a == 8'h24 || a == 8'h28) return m_lvl;
      if (a == 8'h08) return 16'h0002;
      return m_reg[a[4:2]];
   endfunction

   task automatic do_read(string req, logic [7:0] a);
      @(negedge clk);
      bus_addr = a;
      bus_we   = 1'b0;
      #1;
      check(req, $sformatf("read %h", a), bus_rdata, exp_read(a));
   endtask

   // write with optional external strobes in the same cycle
   task automatic do_write(string req, logic [7:0] a, logic [31:0] d,
                           logic [15:0] stb, logic [15:0] val);
      logic [15:0] w, exp_out, exp_chg;
      logic        ev;
      w = d[15:0];
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      ext_stb = stb; ext_val = val;
      @(negedge clk);
      bus_we = 1'b0; ext_stb = '0;
      ev = 1'b0;
      if (a == 8'h20) begin
         m_dir = w;
         exp_out = m_lvl & m_dir;
         m_lvl = (m_lvl & ~stb) | (val & stb);
         ev = 1'b1;
      end else if (a == 8'h24 || a == 8'h28) begin
         m_lvl = w & m_dir;
         exp_out = m_lvl & m_dir;
         ev = 1'b1;
      end else begin
         m_lvl = (m_lvl & ~stb) | (val & stb);
         exp_out = m_out;
         if (a[1:0] == 2'b00 && a <= 8'h1c && a != 8'h08) begin
            if (a == 8'h0c && w[7]) m_reg[3] = w | 16'h8040;
            else m_reg[a[4:2]] = w;
         end
      end
      exp_chg = ev ? (exp_out ^ m_out) : 16'h0;
      m_out = exp_out;
      check(req, "gpio_out after write", gpio_out, exp_out);
      check(ev ? "R5" : "R9", "out_changed after write", out_changed, exp_chg);
   endtask

   task automatic do_ext(logic [15:0] stb, logic [15:0] val);
      @(negedge clk);
      ext_stb = stb; ext_val = val;
      @(negedge clk);
      ext_stb = '0;
      m_lvl = (m_lvl & ~stb) | (val & stb);
      check("R6", "gpio_out after ext", gpio_out, m_out);
      check("R6", "out_changed after ext", out_changed, 16'h0);
   endtask

   localparam logic [7:0] ADDRS [0:13] = '{8'h00, 8'h04, 8'h08, 8'h0c, 8'h10,
      8'h14, 8'h18, 8'h1c, 8'h20, 8'h24, 8'h28, 8'h2c, 8'h01, 8'hfc};

   initial begin
      void'($urandom(32'd7919));
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      m_dir = '0; m_lvl = '0; m_out = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", "gpio_out at reset", gpio_out, 16'h0);
      check("R1", "out_changed at reset", out_changed, 16'h0);
      for (int i = 0; i < 11; i++) do_read("R1", ADDRS[i]);
      // R2 truncation of the upper half
      do_write("R2", 8'h00, 32'hDEAD_1234, '0, '0);
      do_read("R2", 8'h00);
      do_write("R2", 8'h1c, 32'hFFFF_A5A5, '0, '0);
      do_read("R2", 8'h1c);
      // R3 power forcing
      do_write("R3", 8'h0c, 32'h0000_0080, '0, '0);
      check("R3", "power forced", exp_read(8'h0c), 16'h80C0);
      do_read("R3", 8'h0c);
      do_write("R3", 8'h0c, 32'h0000_0101, '0, '0);
      do_read("R3", 8'h0c);
      // R8 status and unmapped writes ignored
      do_write("R8", 8'h08, 32'h0000_FFFF, '0, '0);
      do_read("R8", 8'h08);
      do_write("R8", 8'h2c, 32'h0000_FFFF, '0, '0);
      do_read("R8", 8'h2c);
      do_read("R8", 8'h03);
      // R4 level masked by direction, aliases
      do_write("R4", 8'h24, 32'h0000_FFFF, '0, '0);
      do_read("R4", 8'h28);
      do_write("R4", 8'h20, 32'h0000_0F0F, '0, '0);
      do_write("R4", 8'h28, 32'h0000_FFFF, '0, '0);
      do_read("R4", 8'h24);
      do_read("R4", 8'h20);
      // R6 external update invisible until evaluation, then R5
      do_ext(16'hF0F0, 16'hF0F0);
      do_read("R6", 8'h24);
      do_write("R5", 8'h20, 32'h0000_FFFF, '0, '0);
      // R7 bus write beats external strobes
      do_write("R7", 8'h24, 32'h0000_00FF, 16'hFFFF, 16'hFF00);
      do_read("R7", 8'h24);
      // random traffic
      for (int n = 0; n < 600; n++) begin
         int kind;
         logic [7:0] a;
         logic [15:0] s, v;
         kind = $urandom_range(0, 3);
         a = ADDRS[$urandom_range(0, 13)];
         s = 16'($urandom); v = 16'($urandom);
         case (kind)
            0: do_read("R2", a);
            1: do_ext(s, v);
            default: begin
               if (a == 8'h20) s = '0;
               do_write((a == 8'h24 || a == 8'h28) ? "R7" : "R4", a, $urandom, s, v);
            end
         endcase
      end
      do_read("R9", 8'h24);
      check("R9", "out_changed idle", out_changed, 16'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule